// File: doc/BRIEF.md
# Cascadable Synchronous Binary Counter

This block is a small synchronous up-counter, four bits wide by default. On each rising clock edge it does one of four things: it clears, it loads a data word, it increments, or it holds. Clear takes precedence over load, and load takes precedence over counting. Counting needs two enables. The carry output is gated by only one of them, so that several stages can be chained into a wider counter. In a chain, each stage's carry feeds both enables of the stage above it.

A build-time mode parameter shapes the count sequence:

- **Free-running:** the counter wraps from all-ones to zero.
- **Reload:** after all-ones, the counter reloads a programmable start value.
- **Clear-at-end:** after a programmable end value, the counter returns to zero.

The reload and clear-at-end modes give modulo-N dividers without any external logic.

Top module: `sync_counter4`

## Requirements
- R1: A high `rst` at a rising edge sets `count` to 0, whatever the other inputs are.
- R2: A high `clr` at a rising edge sets `count` to 0. This overrides `load` and counting.
- R3: With `clr` low and `load` high, a rising edge copies `din` into `count`, whatever the enables are.
- R4: With `clr` and `load` low and both `en_p` and `en_t` high, `count` increases by one, except at the wrap point of the selected mode.
- R5: With `clr` and `load` low and either enable low, `count` holds its value.
- R6: `carry` is high exactly when `en_t` is high and `count` is all ones. It does not depend on `en_p`, and it changes in the same cycle as its inputs.
- R7: In free-running mode (MODE=0), counting from all ones gives 0.
- R8: In reload mode (MODE=1), counting from all ones gives START. With the defaults the sequence is 5..15, then 5 again.
- R9: In clear-at-end mode (MODE=2), counting from END_VAL gives 0. With the defaults the sequence is 0..10, then 0 again.
- R10: Two stages, with the lower stage's `carry` driving both enables of the upper stage, count as one 8-bit binary counter. The upper stage's `carry` is high at 255.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| clr | input | 1 | Synchronous clear, active high, highest priority |
| load | input | 1 | Synchronous parallel load, active high |
| en_p | input | 1 | Count enable that does not gate the carry |
| en_t | input | 1 | Count enable that also gates the carry |
| din | input | WIDTH | Parallel load data |
| count | output | WIDTH | Current count |
| carry | output | 1 | Terminal-count carry for cascading |

## Verification
The bench builds the block three times, with MODE=0, MODE=1 (START=5) and MODE=2 (END_VAL=10). This brings all three wrap behaviours within reach from one stimulus stream. It also chains two default-parameter stages into an 8-bit counter and walks the pair through all 256 states. This shows that the carry-gated enable makes the upper stage advance only when the lower stage rolls over.

// File: rtl/sync_counter4.sv
module sync_counter4 #(
  parameter int WIDTH   = 4,
  parameter int MODE    = 0,
  parameter int START   = 5,
  parameter int END_VAL = 10
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             en_p,
  input  logic             en_t,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] count,
  output logic             carry
);
  localparam logic [WIDTH-1:0] MAX_V   = '1;
  localparam logic [WIDTH-1:0] START_V = WIDTH'(START);
  localparam logic [WIDTH-1:0] END_V   = WIDTH'(END_VAL);
  localparam logic [WIDTH-1:0] ONE_V   = WIDTH'(1);

  logic             step;
  logic             at_wrap;
  logic [WIDTH-1:0] wrap_v;
  logic [WIDTH-1:0] next_v;

  assign step = en_p & en_t;

  generate
    if (MODE == 1) begin : g_reload
      assign at_wrap = (count == MAX_V);
      assign wrap_v  = START_V;
    end else if (MODE == 2) begin : g_clrend
      assign at_wrap = (count == END_V);
      assign wrap_v  = '0;
    end else begin : g_free
      assign at_wrap = (count == MAX_V);
      assign wrap_v  = '0;
    end
  endgenerate

  assign next_v = at_wrap ? wrap_v : count + ONE_V;

  always_ff @(posedge clk) begin
    if (rst || clr)   count <= '0;
    else if (load)    count <= din;
    else if (step)    count <= next_v;
  end

  assign carry = en_t && (count == MAX_V);

  AST_RESET_ZERO: assert property (@(posedge clk) rst |=> count == '0); // R1
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> count == '0); // R2
  AST_LOAD_COPIES: assert property (@(posedge clk) disable iff (rst)
    (!clr && load) |=> count == $past(din)); // R3
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && !(en_p && en_t)) |=> $stable(count)); // R5
  AST_STEP_INC: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && en_p && en_t && count != MAX_V && !(MODE == 2 && count == END_V))
    |=> count == $past(count) + ONE_V); // R4

  generate
    if (MODE == 1) begin : g_chk_reload
      AST_RELOAD_START: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && en_p && en_t && count == MAX_V) |=> count == START_V); // R8
    end else if (MODE == 2) begin : g_chk_clrend
      AST_END_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && en_p && en_t && count == END_V) |=> count == '0); // R9
    end else begin : g_chk_free
      AST_FREE_WRAP: assert property (@(posedge clk) disable iff (rst)
        (!clr && !load && en_p && en_t && count == MAX_V) |=> count == '0); // R7
    end
  endgenerate
endmodule

// File: tb/sync_counter4_tb.sv
module sync_counter4_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 12;
  // {clr, load, en_p, en_t, din[3:0], exp_count[3:0], exp_carry}
  localparam logic [12:0] VEC [NVEC] = '{
    13'b0_0_1_1_0000_0001_0,
    13'b0_1_1_1_1110_1110_0,
    13'b0_0_1_1_0000_1111_1,
    13'b0_0_0_1_0000_1111_1,
    13'b0_0_1_0_0000_1111_0,
    13'b0_0_1_1_0000_0000_0,
    13'b1_1_1_1_1001_0000_0,
    13'b0_1_0_0_1001_1001_0,
    13'b0_0_0_0_0000_1001_0,
    13'b0_1_1_1_0011_0011_0,
    13'b1_0_1_1_0000_0000_0,
    13'b0_0_1_1_0000_0001_0
  };

  logic clk = 1'b0, rst = 1'b1, clr = 1'b0, load = 1'b0, en_p = 1'b0, en_t = 1'b0;
  logic [3:0] din = '0;
  logic [3:0] cnt_free, cnt_rel, cnt_clr;
  logic cy_free, cy_rel, cy_clr;
  logic cen = 1'b0;
  logic [3:0] lo_q, hi_q;
  logic lo_cy, hi_cy;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_counter4 u_dut (.clk(clk), .rst(rst), .clr(clr), .load(load), .en_p(en_p), .en_t(en_t),
    .din(din), .count(cnt_free), .carry(cy_free));
  sync_counter4 #(.MODE(1), .START(5)) u_rel (.clk(clk), .rst(rst), .clr(clr), .load(load),
    .en_p(en_p), .en_t(en_t), .din(din), .count(cnt_rel), .carry(cy_rel));
  sync_counter4 #(.MODE(2), .END_VAL(10)) u_clr (.clk(clk), .rst(rst), .clr(clr), .load(load),
    .en_p(en_p), .en_t(en_t), .din(din), .count(cnt_clr), .carry(cy_clr));
  sync_counter4 u_lo (.clk(clk), .rst(rst), .clr(1'b0), .load(1'b0), .en_p(cen), .en_t(cen),
    .din(4'd0), .count(lo_q), .carry(lo_cy));
  sync_counter4 u_hi (.clk(clk), .rst(rst), .clr(1'b0), .load(1'b0), .en_p(lo_cy), .en_t(lo_cy),
    .din(4'd0), .count(hi_q), .carry(hi_cy));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic drive(input logic c, input logic l, input logic p, input logic t, input logic [3:0] d);
    clr = c; load = l; en_p = p; en_t = t; din = d;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    chk(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    tick(); tick();
    chk(cnt_free == 4'd0, "R1 reset count", cnt_free, 0);
    chk(cy_free == 1'b0, "R6 reset carry", cy_free, 0);
    rst = 1'b0;
    // table: R2 R3 R4 R5 R6 R7
    for (int i = 0; i < NVEC; i++) begin
      drive(VEC[i][12], VEC[i][11], VEC[i][10], VEC[i][9], VEC[i][8:5]);
      tick();
      chk(cnt_free == VEC[i][4:1], "R2-R7 table count", cnt_free, VEC[i][4:1]);
      chk(cy_free == VEC[i][0], "R6 table carry", cy_free, VEC[i][0]);
    end
    // R1: reset beats load and count
    drive(1'b0, 1'b1, 1'b1, 1'b1, 4'd7); rst = 1'b1;
    tick();
    chk(cnt_free == 4'd0, "R1 reset wins", cnt_free, 0);
    rst = 1'b0;
    // R8: reload mode
    drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd13); tick();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
    tick(); chk(cnt_rel == 4'd14, "R8 reload step", cnt_rel, 14);
    tick(); chk(cnt_rel == 4'd15, "R8 reload top", cnt_rel, 15);
    chk(cy_rel == 1'b1, "R6 reload carry", cy_rel, 1);
    tick(); chk(cnt_rel == 4'd5, "R8 reload start", cnt_rel, 5);
    tick(); chk(cnt_rel == 4'd6, "R8 reload after", cnt_rel, 6);
    // R9: clear-at-end mode
    drive(1'b0, 1'b1, 1'b0, 1'b0, 4'd9); tick();
    drive(1'b0, 1'b0, 1'b1, 1'b1, 4'd0);
    tick(); chk(cnt_clr == 4'd10, "R9 end value", cnt_clr, 10);
    tick(); chk(cnt_clr == 4'd0, "R9 clear after end", cnt_clr, 0);
    tick(); chk(cnt_clr == 4'd1, "R9 restart", cnt_clr, 1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 4'd0);
    // R10: cascade through all 256 states
    rst = 1'b1; tick(); rst = 1'b0;
    cen = 1'b1;
    for (int i = 1; i <= 256; i++) begin
      tick();
      chk({hi_q, lo_q} == 8'(i), "R10 cascade value", {hi_q, lo_q}, i % 256);
      if (i == 255) chk(hi_cy == 1'b1, "R10 cascade carry", hi_cy, 1);
      if (i == 254) chk(hi_cy == 1'b0, "R10 cascade no carry", hi_cy, 0);
    end
    cen = 1'b0;
    tick();
    chk({hi_q, lo_q} == 8'd0, "R10 cascade hold", {hi_q, lo_q}, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule